// File: doc/BRIEF.md
# Conditional Relative Branch Sequencer

This block steps an 8-bit processor core through its conditional relative branches once the opcode byte has been fetched. A one-cycle start strobe hands it the opcode, the program counter that points at the first operand byte, the A, X and Y register values and the N, V, Z and C status flags. All of these are captured on that edge. From the next cycle the block drives exactly one action per cycle: an operand read at the program counter, a read or write of a zero-page byte, or an idle cycle. It decides whether the branch is taken and, if it is, adds the sign-extended 8-bit displacement to the 16-bit program counter.

A branch can test one of the four status flags, or a single bit of a zero-page byte chosen by the opcode. It can also compare A with a zero-page byte, either at a direct address or at that address plus X. Two loop forms decrement a value first: one decrements a zero-page byte in memory, the other decrements Y. A not-taken branch ends as soon as its condition is known. A taken branch always adds two idle cycles, and the program counter is updated in the second of them. `done_o` marks the final cycle of every instruction, so the surrounding core can sequence on it.

The memory port has zero wait states. `mem_rdata_i` must be valid in the same cycle as `mem_rd_o`, and a write takes effect at the end of the cycle in which `mem_wr_o` is high. A zero-page address is `{8'h00, offset}`, and adding X to the offset wraps within 8 bits. The program counter wraps modulo 2^16.

Top module: `rel_branch_seq`

## Requirements
- R1: While `rst_ni` is low and after its release, `busy_o`, `done_o`, `mem_rd_o`, `mem_wr_o` and `y_we_o` are 0, and `pc_o` is 0.
- R2: Opcodes with low nibble 0 and bit 4 set test one flag. opcode[7:6] selects the flag (00=N, 01=V, 10=C, 11=Z). The branch is taken when that flag equals opcode[5]. The sequence is one operand read, plus two idle cycles when taken (1 or 3 cycles).
- R3: Opcode 0x2F is always taken and takes 3 cycles: an operand read followed by two idle cycles.
- R4: An opcode with low nibble 3 tests bit opcode[7:5] of a zero-page byte. It is taken when that bit equals NOT opcode[4]. The sequence is: read the offset, read the zero-page byte, read the displacement, one idle cycle, plus two idle cycles when taken (4 or 6 cycles).
- R5: Opcode 0x2E follows the R4 sequence and is taken when A differs from the zero-page byte (4 or 6 cycles).
- R6: Opcode 0xDE reads the offset and then spends one idle cycle. It then reads zero-page address (offset+X) mod 256, reads the displacement, and spends one idle cycle. It is taken when A differs from the byte read (5 or 7 cycles).
- R7: Opcode 0x6E reads the offset, reads the zero-page byte, and writes (byte-1) mod 256 back to the same address. It then reads the displacement and is taken when the written value is nonzero (4 or 6 cycles).
- R8: Opcode 0xFE reads the displacement, then spends an idle cycle in which `y_we_o` is high for exactly one cycle with `y_o` = (Y-1) mod 256. It then spends one idle cycle and is taken when that value is nonzero (3 or 5 cycles).
- R9: Operand reads use addresses PC, PC+1 in order. After the instruction, `pc_o` is PC plus the number of operand bytes, plus the sign-extended displacement when taken, all modulo 2^16.
- R10: `busy_o` is high from the cycle after an accepted start through the last cycle. `done_o` is high only in that last cycle, for one cycle.
- R11: `mem_rd_o` and `mem_wr_o` are never high together, and idle cycles drive neither.
- R12: Any other opcode produces one idle cycle with `done_o` high and leaves `pc_o` unchanged.
- R13: `start_i` and all register, flag and opcode inputs are ignored while `busy_o` is high, and `pc_o` holds while the block is idle with no start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a branch; accepted only when not busy |
| opcode_i | input | 8 | Opcode captured at start |
| pc_i | input | 16 | Address of the first operand byte |
| a_i | input | 8 | Accumulator value |
| x_i | input | 8 | X index value |
| y_i | input | 8 | Y register value |
| n_i | input | 1 | Negative flag |
| v_i | input | 1 | Overflow flag |
| z_i | input | 1 | Zero flag |
| c_i | input | 1 | Carry flag |
| mem_rdata_i | input | 8 | Read data, valid in the read cycle |
| mem_addr_o | output | 16 | Memory address |
| mem_rd_o | output | 1 | Read strobe |
| mem_wr_o | output | 1 | Write strobe |
| mem_wdata_o | output | 8 | Write data |
| pc_o | output | 16 | Program counter |
| y_o | output | 8 | Decremented Y value |
| y_we_o | output | 1 | Y write strobe |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | Last cycle of the instruction |

## Verification
For the flag branches and the memory-decrement loop, the displacement read and the taken decision fall in the same cycle. When such a branch is not taken, that cycle is also the final one. The bench provokes this by sweeping every flag opcode over all sixteen flag combinations, and by running the memory decrement with bytes of 1, 2, 0 and 0x80. In each case it judges whether `done_o` rises in the displacement-read cycle with the program counter advanced by exactly one operand byte, or instead rises two idle cycles later with the displacement applied. Branches whose condition is settled in a separate idle cycle are swept alongside them for contrast.

// File: rtl/br_pkg.sv
package br_pkg;
  typedef enum logic [2:0] {
    K_NONE, K_FLAG, K_BIT, K_CMP, K_CMPX, K_DECM, K_DECY
  } kind_e;

  typedef enum logic [3:0] {
    S_IDLE, S_NOP, S_DPF, S_XIDLE, S_DPRD, S_DPWR,
    S_RELF, S_YDEC, S_EVAL, S_TK1, S_TK2
  } state_e;

  // flag vector index matches opcode[7:6]
  localparam int FLAG_N = 0;
  localparam int FLAG_V = 1;
  localparam int FLAG_C = 2;
  localparam int FLAG_Z = 3;
  localparam int NUM_FLAGS = 4;

  typedef struct packed {
    kind_e      kind;
    logic [1:0] flag_sel;
    logic       want_set;
    logic       always_tk;
    logic [2:0] bit_idx;
  } dec_t;
endpackage

// File: rtl/br_decode.sv
module br_decode
  import br_pkg::*;
(
  input  logic [7:0] op_i,
  output dec_t       dec_o
);
  always_comb begin
    dec_o           = '0;
    dec_o.kind      = K_NONE;
    dec_o.flag_sel  = op_i[7:6];
    dec_o.want_set  = op_i[5];
    dec_o.bit_idx   = op_i[7:5];
    dec_o.always_tk = 1'b0;
    if (op_i[3:0] == 4'h0 && op_i[4]) begin
      dec_o.kind = K_FLAG;
    end else if (op_i[3:0] == 4'h3) begin
      dec_o.kind     = K_BIT;
      dec_o.want_set = ~op_i[4];
    end else begin
      case (op_i)
        8'h2F: begin
          dec_o.kind      = K_FLAG;
          dec_o.always_tk = 1'b1;
        end
        8'h2E:   dec_o.kind = K_CMP;
        8'hDE:   dec_o.kind = K_CMPX;
        8'h6E:   dec_o.kind = K_DECM;
        8'hFE:   dec_o.kind = K_DECY;
        default: dec_o.kind = K_NONE;
      endcase
    end
  end
endmodule

// File: rtl/br_cond.sv
module br_cond
  import br_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  dec_t                dec_i,
  input  logic [NUM_FLAGS-1:0] flags_i,
  input  logic [DATA_W-1:0]   val_i,
  input  logic [DATA_W-1:0]   acc_i,
  input  logic [DATA_W-1:0]   cnt_i,
  output logic                taken_o
);
  always_comb begin
    case (dec_i.kind)
      K_FLAG:         taken_o = dec_i.always_tk | (flags_i[dec_i.flag_sel] == dec_i.want_set);
      K_BIT:          taken_o = (val_i[dec_i.bit_idx] == dec_i.want_set);
      K_CMP, K_CMPX:  taken_o = (acc_i != val_i);
      K_DECM:         taken_o = (val_i != '0);
      K_DECY:         taken_o = (cnt_i != '0);
      default:        taken_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/br_fsm.sv
module br_fsm
  import br_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  kind_e  kind_i,
  input  logic   taken_i,
  output state_e state_o,
  output logic   done_o
);
  state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    done_o  = 1'b0;
    case (state_q)
      S_IDLE: if (start_i) begin
        case (kind_i)
          K_FLAG, K_DECY:               state_d = S_RELF;
          K_BIT, K_CMP, K_CMPX, K_DECM: state_d = S_DPF;
          default:                      state_d = S_NOP;
        endcase
      end
      S_NOP: begin
        done_o  = 1'b1;
        state_d = S_IDLE;
      end
      S_DPF:   state_d = (kind_i == K_CMPX) ? S_XIDLE : S_DPRD;
      S_XIDLE: state_d = S_DPRD;
      S_DPRD:  state_d = (kind_i == K_DECM) ? S_DPWR : S_RELF;
      S_DPWR:  state_d = S_RELF;
      S_RELF: begin
        case (kind_i)
          K_FLAG, K_DECM: begin
            state_d = taken_i ? S_TK1 : S_IDLE;
            done_o  = ~taken_i;
          end
          K_DECY:  state_d = S_YDEC;
          default: state_d = S_EVAL;
        endcase
      end
      S_YDEC: state_d = S_EVAL;
      S_EVAL: begin
        state_d = taken_i ? S_TK1 : S_IDLE;
        done_o  = ~taken_i;
      end
      S_TK1: state_d = S_TK2;
      S_TK2: begin
        done_o  = 1'b1;
        state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  assert_taken_tail_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == S_TK1 |=> state_q == S_TK2);
  assert_done_not_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> state_q != S_IDLE);
endmodule

// File: rtl/rel_branch_seq.sv
module rel_branch_seq
  import br_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [7:0]        opcode_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] y_i,
  input  logic              n_i,
  input  logic              v_i,
  input  logic              z_i,
  input  logic              c_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [DATA_W-1:0] y_o,
  output logic              y_we_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int EXT_W = ADDR_W - DATA_W;
  localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(1);
  localparam logic [DATA_W-1:0] ONE     = DATA_W'(1);

  state_e                state;
  dec_t                  dec;
  logic                  taken;
  logic [7:0]            op_q;
  logic [ADDR_W-1:0]     pc_q;
  logic [DATA_W-1:0]     a_q, x_q, y_q, dp_q, val_q, disp_q;
  logic [NUM_FLAGS-1:0]  flags_q;
  logic [DATA_W-1:0]     dp_eff;

  // decode the live opcode while idle so the first step is chosen at start
  br_decode u_dec (
    .op_i  ((state == S_IDLE) ? opcode_i : op_q),
    .dec_o (dec)
  );

  br_cond #(.DATA_W(DATA_W)) u_cond (
    .dec_i   (dec),
    .flags_i (flags_q),
    .val_i   (val_q),
    .acc_i   (a_q),
    .cnt_i   (y_q),
    .taken_o (taken)
  );

  br_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .kind_i  (dec.kind),
    .taken_i (taken),
    .state_o (state),
    .done_o  (done_o)
  );

  assign dp_eff = dp_q + ((dec.kind == K_CMPX) ? x_q : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q    <= '0;
      pc_q    <= '0;
      a_q     <= '0;
      x_q     <= '0;
      y_q     <= '0;
      dp_q    <= '0;
      val_q   <= '0;
      disp_q  <= '0;
      flags_q <= '0;
    end else begin
      case (state)
        S_IDLE: if (start_i) begin
          op_q    <= opcode_i;
          pc_q    <= pc_i;
          a_q     <= a_i;
          x_q     <= x_i;
          y_q     <= y_i;
          flags_q <= {z_i, c_i, v_i, n_i};
        end
        S_DPF: begin
          dp_q <= mem_rdata_i;
          pc_q <= pc_q + PC_STEP;
        end
        S_DPRD: val_q <= mem_rdata_i;
        S_DPWR: val_q <= val_q - ONE;
        S_RELF: begin
          disp_q <= mem_rdata_i;
          pc_q   <= pc_q + PC_STEP;
        end
        S_YDEC: y_q  <= y_q - ONE;
        S_TK2:  pc_q <= pc_q + {{EXT_W{disp_q[DATA_W-1]}}, disp_q};
        default: ;
      endcase
    end
  end

  always_comb begin
    mem_rd_o   = 1'b0;
    mem_wr_o   = 1'b0;
    mem_addr_o = '0;
    case (state)
      S_DPF, S_RELF: begin
        mem_rd_o   = 1'b1;
        mem_addr_o = pc_q;
      end
      S_DPRD: begin
        mem_rd_o   = 1'b1;
        mem_addr_o = {{EXT_W{1'b0}}, dp_eff};
      end
      S_DPWR: begin
        mem_wr_o   = 1'b1;
        mem_addr_o = {{EXT_W{1'b0}}, dp_eff};
      end
      default: ;
    endcase
  end

  assign mem_wdata_o = val_q - ONE;
  assign y_o         = y_q - ONE;
  assign y_we_o      = (state == S_YDEC);
  assign busy_o      = (state != S_IDLE);
  assign pc_o        = pc_q;

  assert_single_bus_op_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));
  assert_write_follows_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> ($past(mem_rd_o) && $past(mem_addr_o) == mem_addr_o));
  assert_y_strobe_once_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    y_we_o |=> !y_we_o);
  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);
  assert_pc_hold_idle_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(pc_o));
endmodule

// File: tb/tb_rel_branch_seq.sv
module tb_rel_branch_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = '0;
  logic [15:0] pc_in = '0;
  logic [7:0]  a_in = '0, x_in = '0, y_in = '0;
  logic        n_in = 0, v_in = 0, z_in = 0, c_in = 0;
  logic [7:0]  rdata;
  logic [15:0] maddr;
  logic        mrd, mwr;
  logic [7:0]  wdata;
  logic [15:0] pc_out;
  logic [7:0]  y_out;
  logic        y_we, busy, done;

  logic [7:0] mem [256];
  int total = 0, bad = 0, cyc = 0;

  always #2 clk = ~clk;

  rel_branch_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .opcode_i(opcode), .pc_i(pc_in),
    .a_i(a_in), .x_i(x_in), .y_i(y_in), .n_i(n_in), .v_i(v_in), .z_i(z_in), .c_i(c_in),
    .mem_rdata_i(rdata), .mem_addr_o(maddr), .mem_rd_o(mrd), .mem_wr_o(mwr),
    .mem_wdata_o(wdata), .pc_o(pc_out), .y_o(y_out), .y_we_o(y_we),
    .busy_o(busy), .done_o(done)
  );

  assign rdata = mem[maddr[7:0]];
  always @(posedge clk) if (mwr) mem[maddr[7:0]] <= wdata;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic run_br(input logic [7:0] op, input logic [15:0] pc0,
                        input logic [7:0] a, input logic [7:0] x, input logic [7:0] y,
                        input logic [3:0] nvzc, input logic [7:0] b0, input logic [7:0] b1,
                        input logic [7:0] dpv, input bit hold);
    int k, L, nf, nwe;
    int ek[12];
    logic [15:0] ea[12];
    bit tk, flag;
    logic [7:0] disp, dpa, yv;
    logic [15:0] pc1, exp_pc;
    string req;

    if (op[3:0] == 4'h0 && op[4]) k = 1;
    else if (op == 8'h2F) k = 1;
    else if (op[3:0] == 4'h3) k = 2;
    else if (op == 8'h2E) k = 3;
    else if (op == 8'hDE) k = 4;
    else if (op == 8'h6E) k = 5;
    else if (op == 8'hFE) k = 6;
    else k = 0;

    pc1 = pc0 + 16'd1;
    dpa = (k == 4) ? b0 + x : b0;
    disp = (k == 1 || k == 6) ? b0 : b1;
    L = 0;
    tk = 0;
    nf = 0;
    case (k)
      1: begin
        case (op[7:6])
          2'b00: flag = nvzc[3];
          2'b01: flag = nvzc[2];
          2'b10: flag = nvzc[0];
          default: flag = nvzc[1];
        endcase
        tk = (op == 8'h2F) || (flag == op[5]);
        ek[0] = 1; ea[0] = pc0; L = 1; nf = 1;
        req = (op == 8'h2F) ? "R3" : "R2";
      end
      2, 3: begin
        tk = (k == 2) ? (dpv[op[7:5]] == !op[4]) : (a != dpv);
        ek[0] = 1; ea[0] = pc0; ek[1] = 1; ea[1] = {8'h00, dpa};
        ek[2] = 1; ea[2] = pc1; ek[3] = 0; ea[3] = 0; L = 4; nf = 2;
        req = (k == 2) ? "R4" : "R5";
      end
      4: begin
        tk = (a != dpv);
        ek[0] = 1; ea[0] = pc0; ek[1] = 0; ea[1] = 0; ek[2] = 1; ea[2] = {8'h00, dpa};
        ek[3] = 1; ea[3] = pc1; ek[4] = 0; ea[4] = 0; L = 5; nf = 2;
        req = "R6";
      end
      5: begin
        tk = ((dpv - 8'd1) != 8'd0);
        ek[0] = 1; ea[0] = pc0; ek[1] = 1; ea[1] = {8'h00, dpa};
        ek[2] = 2; ea[2] = {8'h00, dpa}; ek[3] = 1; ea[3] = pc1; L = 4; nf = 2;
        req = "R7";
      end
      6: begin
        tk = ((y - 8'd1) != 8'd0);
        ek[0] = 1; ea[0] = pc0; ek[1] = 0; ea[1] = 0; ek[2] = 0; ea[2] = 0; L = 3; nf = 1;
        req = "R8";
      end
      default: begin
        ek[0] = 0; ea[0] = 0; L = 1; nf = 0;
        req = "R12";
      end
    endcase
    if (tk) begin
      ek[L] = 0; ea[L] = 0; L++;
      ek[L] = 0; ea[L] = 0; L++;
    end
    exp_pc = pc0 + 16'(nf) + (tk ? {{8{disp[7]}}, disp} : 16'd0);

    @(negedge clk);
    mem[pc0[7:0]] = b0;
    mem[pc1[7:0]] = b1;
    if (k >= 2 && k <= 5) mem[dpa] = dpv;
    opcode = op; pc_in = pc0; a_in = a; x_in = x; y_in = y;
    {n_in, v_in, z_in, c_in} = nvzc;
    start = 1'b1;
    @(negedge clk);
    if (hold) begin
      // R13: scramble every input while busy; results must follow the captured values
      opcode = 8'h2F; pc_in = ~pc0; a_in = ~a; x_in = ~x; y_in = ~y;
      {n_in, v_in, z_in, c_in} = ~nvzc;
    end else start = 1'b0;

    nwe = 0;
    yv = 8'h00;
    for (int n = 0; n < L; n++) begin
      chk({req, " R11 bus kind"}, mwr ? 2 : (mrd ? 1 : 0), ek[n]);
      if (ek[n] != 0) chk({req, " R9 bus addr"}, maddr, ea[n]);
      chk({req, " R10 done timing"}, done, (n == L - 1) ? 1 : 0);
      chk({req, " R10 busy"}, busy, 1);
      if (y_we) begin
        nwe++;
        yv = y_out;
      end
      if (n == L - 1) start = 1'b0;
      @(negedge clk);
    end
    chk({req, " R9 final pc"}, pc_out, exp_pc);
    chk({req, " R10 idle after done"}, {busy, done}, 0);
    chk({req, " R8 y strobe count"}, nwe, (k == 6) ? 1 : 0);
    if (k == 6) chk("R8 y value", yv, 8'(y - 8'd1));
    if (k == 5) chk("R7 written byte", mem[dpa], 8'(dpv - 8'd1));
    if (hold) chk("R13 restart ignored while busy", busy, 0);
  endtask

  initial begin
    logic [7:0] fops[9];
    fops = '{8'h10, 8'h30, 8'h50, 8'h70, 8'h90, 8'hB0, 8'hD0, 8'hF0, 8'h2F};
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;

    repeat (3) @(negedge clk);
    chk("R1 reset busy/done", {busy, done}, 0);
    chk("R1 reset bus", {mrd, mwr, y_we}, 0);
    chk("R1 reset pc", pc_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {busy, done, mrd, mwr}, 0);

    // flag branches over every flag combination
    for (int f = 0; f < 9; f++)
      for (int c = 0; c < 16; c++)
        run_br(fops[f], 16'h12A0, 8'h00, 8'h00, 8'h00, 4'(c),
               8'(c * 8'd23 + 8'd3), 8'h00, 8'h00, (c == 5));

    // displacement extremes and pc wraparound
    run_br(8'h2F, 16'hFFFE, 0, 0, 0, 4'h0, 8'h7F, 8'h00, 8'h00, 0);
    run_br(8'h2F, 16'hFFFE, 0, 0, 0, 4'h0, 8'h80, 8'h00, 8'h00, 0);
    run_br(8'h2F, 16'h00F0, 0, 0, 0, 4'h0, 8'h80, 8'h00, 8'h00, 0);
    run_br(8'h2F, 16'h00F0, 0, 0, 0, 4'h0, 8'h00, 8'h00, 8'h00, 0);
    run_br(8'hF0, 16'hFFFE, 0, 0, 0, 4'h2, 8'hFE, 8'h00, 8'h00, 0);

    // bit tests: every opcode with its bit alone set, and with only it clear
    for (int o = 0; o < 16; o++) begin
      logic [7:0] op;
      op = {4'(o), 4'h3};
      run_br(op, 16'h12A0, 0, 0, 0, 4'h0, 8'h30, 8'hF6, 8'(1 << op[7:5]), (o == 3));
      run_br(op, 16'h12A0, 0, 0, 0, 4'h0, 8'h31, 8'h0C, ~8'(1 << op[7:5]), 0);
      run_br(op, 16'hFFFE, 0, 0, 0, 4'h0, 8'h22, 8'h85, (o[0] ? 8'hFF : 8'h00), 0);
    end

    // compare with A
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 2; j++) begin
        logic [7:0] av, dv;
        av = (i == 0) ? 8'h00 : (i == 1) ? 8'h55 : 8'hFF;
        dv = (j == 0) ? 8'h55 : 8'h00;
        run_br(8'h2E, 16'h12A0, av, 0, 0, 4'h0, 8'h40, 8'hF0, dv, 0);
        run_br(8'hDE, 16'h12A0, av, 8'h10, 0, 4'h0, 8'h30, 8'h10, dv, (i == 2));
      end
    run_br(8'hDE, 16'h00F0, 8'h12, 8'hC0, 0, 4'h0, 8'h80, 8'h09, 8'h12, 0);
    run_br(8'hDE, 16'h00F0, 8'h13, 8'hC0, 0, 4'h0, 8'h80, 8'h09, 8'h12, 0);
    run_br(8'hDE, 16'h12A0, 8'h00, 8'hFF, 0, 4'h0, 8'h51, 8'hFA, 8'h01, 0);

    // memory decrement loop
    run_br(8'h6E, 16'h12A0, 0, 0, 0, 4'h0, 8'h44, 8'hF8, 8'h01, 0);
    run_br(8'h6E, 16'h12A0, 0, 0, 0, 4'h0, 8'h44, 8'hF8, 8'h02, 0);
    run_br(8'h6E, 16'h12A0, 0, 0, 0, 4'h0, 8'h44, 8'hF8, 8'h00, 1);
    run_br(8'h6E, 16'hFFFE, 0, 0, 0, 4'h0, 8'h45, 8'h03, 8'h80, 0);

    // Y decrement loop
    run_br(8'hFE, 16'h12A0, 0, 0, 8'h01, 4'h0, 8'hFC, 8'h00, 8'h00, 0);
    run_br(8'hFE, 16'h12A0, 0, 0, 8'h00, 4'h0, 8'hFC, 8'h00, 8'h00, 0);
    run_br(8'hFE, 16'h12A0, 0, 0, 8'h02, 4'h0, 8'h10, 8'h00, 8'h00, 1);
    run_br(8'hFE, 16'h00F0, 0, 0, 8'h80, 4'h0, 8'h80, 8'h00, 8'h00, 0);

    // unsupported opcodes
    run_br(8'h00, 16'h12A0, 0, 0, 0, 4'hF, 8'h05, 8'h00, 8'h00, 0);
    run_br(8'h3F, 16'h12A0, 0, 0, 0, 4'hF, 8'h05, 8'h00, 8'h00, 0);
    run_br(8'h12, 16'h12A0, 0, 0, 0, 4'h0, 8'h05, 8'h00, 8'h00, 1);
    run_br(8'hEE, 16'hFFFE, 0, 0, 0, 4'h0, 8'h05, 8'h00, 8'h00, 0);

    // idle with no start: pc holds
    repeat (4) @(negedge clk);
    chk("R13 pc holds while idle", pc_out, 16'hFFFE);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule